// File: doc/BRIEF.md
# Scan-Line Locked CPU Phase Clock Generator

This block divides a master clock running at four times the colour subcarrier into the phase clocks of an 8-bit processor. It does not use a fixed divide ratio. Sixty-four ordinary processor cycles of 14 master ticks are followed by one stretched cycle of 16 ticks. One scan line is therefore 912 master ticks, which is exactly 228 subcarrier periods. Every line begins at the same subcarrier phase, and the average processor cycle comes out a little longer than an ordinary one.

The generator drives three clocks:
- a master phase clock (`phi0`);
- two derived clocks that never overlap, one (`phi1`) active in the low half and one (`phi2`) active in the high half.

It also reports the index of the current processor cycle within the line and raises a single-tick strobe at the start of each line. The stretch goes into the low half of the stretched cycle, so the high half, where data is transferred, always lasts the same time.

Top module: `cpu_line_clkgen`

## Requirements
- R1: While `rst` is sampled high on a rising `clk` edge, the generator is placed at tick 0 of cycle 0. At that point `phi0`, `phi1` and `phi2` are low, `cycleIdx` is 0 and `lineStart` is high.
- R2: Cycles 0 to 63 each last 14 ticks. `phi0` is low for the first 7 ticks and high for the last 7.
- R3: Cycle 64 lasts 16 ticks. `phi0` is low for the first 9 ticks and high for the last 7.
- R4: `cycleIdx` holds the index of the current cycle. It steps by one at each cycle start and wraps from 64 to 0.
- R5: `lineStart` is high only during tick 0 of cycle 0. Successive pulses are 912 ticks apart, which is a multiple of 4.
- R6: `phi1` is high exactly on the ticks where `phi0` is low, except the first and last tick of the low half.
- R7: `phi2` is high exactly on the ticks where `phi0` is high, except the first and last tick of the high half.
- R8: `phi1` and `phi2` are never high on the same tick.
- R9: A reset applied in the middle of a line restarts the generator at tick 0 of cycle 0, and counting resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at four times the subcarrier |
| rst | input | 1 | Synchronous reset, active high |
| phi0 | output | 1 | Master processor phase clock |
| phi1 | output | 1 | Non-overlapping clock active in the low half |
| phi2 | output | 1 | Non-overlapping clock active in the high half |
| cycleIdx | output | 7 | Index of the processor cycle within the line (0..64) |
| lineStart | output | 1 | One-tick strobe at the start of the line |

## Verification
On every tick, the embedded assertions check:
- that `phi1` and `phi2` never overlap and each stays inside its half of `phi0`;
- that each derived clock is low on the tick where `phi0` changes;
- that the tick and cycle counters stay within the limits set for the current cycle;
- that the line strobe lasts a single tick.

Some behaviour can only be shown by the bench's scenarios:
- the exact 7/7 and 9/7 low/high split of each cycle;
- the 912-tick line period and its alignment to the subcarrier;
- restart after a reset in the middle of a line.

The bench shows these by comparing every output against a tick-level model over whole lines.

// File: rtl/cpu_line_clkgen_pkg.sv
package cpu_line_clkgen_pkg;

  // Strobes the sequencer hands to the phase register stage; each one
  // describes the tick that is about to begin.
  typedef struct packed {
    logic phaseHigh;  // next tick lies in the high half of phi0
    logic edgeGuard;  // next tick is first or last of its half
    logic lineBegin;  // next tick is tick 0 of cycle 0
    logic longCycle;  // next tick belongs to the stretched cycle
  } clk_strobe_t;

endpackage

// File: rtl/cpu_line_clkgen_seq.sv
module cpu_line_clkgen_seq
  import cpu_line_clkgen_pkg::*;
#(
  parameter int HALF_TICKS    = 7,
  parameter int STRETCH_TICKS = 2,
  parameter int LINE_CYCLES   = 65
) (
  input  logic                                   clk,
  input  logic                                   rst,
  output logic [$clog2(LINE_CYCLES)-1:0]         cycleCnt,
  output clk_strobe_t                            strobe
);

  localparam int NORM_LEN = 2 * HALF_TICKS;
  localparam int LONG_LEN = NORM_LEN + STRETCH_TICKS;
  localparam int TW       = $clog2(LONG_LEN + 1);
  localparam int CW       = $clog2(LINE_CYCLES);

  localparam logic [TW-1:0] NORM_LAST = TW'(NORM_LEN - 1);
  localparam logic [TW-1:0] LONG_LAST = TW'(LONG_LEN - 1);
  localparam logic [TW-1:0] NORM_LOW  = TW'(HALF_TICKS);
  localparam logic [TW-1:0] LONG_LOW  = TW'(HALF_TICKS + STRETCH_TICKS);
  localparam logic [CW-1:0] LAST_CYC  = CW'(LINE_CYCLES - 1);

  logic [TW-1:0] tickCnt;
  logic [TW-1:0] tickNext;
  logic [CW-1:0] cycNext;
  logic [TW-1:0] curLast;
  logic [TW-1:0] nextLast;
  logic [TW-1:0] nextLow;
  logic          endOfCycle;
  logic          nextLong;

  always_comb begin
    curLast    = (cycleCnt == LAST_CYC) ? LONG_LAST : NORM_LAST;
    endOfCycle = (tickCnt == curLast);
    if (endOfCycle) begin
      tickNext = '0;
      cycNext  = (cycleCnt == LAST_CYC) ? '0 : cycleCnt + 1'b1;
    end else begin
      tickNext = tickCnt + 1'b1;
      cycNext  = cycleCnt;
    end
    nextLong = (cycNext == LAST_CYC);
    nextLow  = nextLong ? LONG_LOW : NORM_LOW;
    nextLast = nextLong ? LONG_LAST : NORM_LAST;

    strobe.phaseHigh = (tickNext >= nextLow);
    strobe.edgeGuard = (tickNext == '0) || (tickNext == nextLow - 1'b1) ||
                       (tickNext == nextLow) || (tickNext == nextLast);
    strobe.lineBegin = (tickNext == '0) && (cycNext == '0);
    strobe.longCycle = nextLong;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt  <= '0;
      cycleCnt <= '0;
    end else begin
      tickCnt  <= tickNext;
      cycleCnt <= cycNext;
    end
  end

  // R4: cycle index never leaves its range
  a_r4_cycle_range: assert property (@(posedge clk) disable iff (rst)
    cycleCnt <= LAST_CYC);

  // R4: the last cycle of a line is followed by cycle 0
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (cycleCnt == LAST_CYC && tickCnt == LONG_LAST) |=> cycleCnt == '0);

  // R3: only the stretched cycle may reach its extra ticks
  a_r3_tick_bound: assert property (@(posedge clk) disable iff (rst)
    (cycleCnt != LAST_CYC) |-> tickCnt <= NORM_LAST);

  // R2: inside a cycle the tick counter advances by one
  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    (tickCnt != NORM_LAST && tickCnt != LONG_LAST) |=>
      tickCnt == $past(tickCnt) + 1'b1);

endmodule

// File: rtl/cpu_line_clkgen_phase.sv
module cpu_line_clkgen_phase
  import cpu_line_clkgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  clk_strobe_t strobe,
  output logic        phi0,
  output logic        phi1,
  output logic        phi2,
  output logic        lineStart
);

  always_ff @(posedge clk) begin
    if (rst) begin
      phi0      <= 1'b0;
      phi1      <= 1'b0;
      phi2      <= 1'b0;
      lineStart <= 1'b1;
    end else begin
      phi0      <= strobe.phaseHigh;
      phi1      <= !strobe.phaseHigh && !strobe.edgeGuard;
      phi2      <= strobe.phaseHigh && !strobe.edgeGuard;
      lineStart <= strobe.lineBegin;
    end
  end

  // R8: the two derived clocks never overlap
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(phi1 && phi2));

  // R6: phi1 stays inside the low half
  a_r6_phi1_low: assert property (@(posedge clk) disable iff (rst)
    phi1 |-> !phi0);

  // R7: phi2 stays inside the high half
  a_r7_phi2_high: assert property (@(posedge clk) disable iff (rst)
    phi2 |-> phi0);

  // R6: phi1 is low on the tick phi0 falls
  a_r6_fall_guard: assert property (@(posedge clk) disable iff (rst)
    $fell(phi0) |-> !phi1);

  // R7: phi2 is low on the tick phi0 rises
  a_r7_rise_guard: assert property (@(posedge clk) disable iff (rst)
    $rose(phi0) |-> !phi2);

  // R5: the line strobe lasts a single tick
  a_r5_one_tick: assert property (@(posedge clk) disable iff (rst)
    lineStart |=> !lineStart);

endmodule

// File: rtl/cpu_line_clkgen.sv
module cpu_line_clkgen
  import cpu_line_clkgen_pkg::*;
#(
  parameter int HALF_TICKS    = 7,
  parameter int STRETCH_TICKS = 2,
  parameter int LINE_CYCLES   = 65
) (
  input  logic                            clk,
  input  logic                            rst,
  output logic                            phi0,
  output logic                            phi1,
  output logic                            phi2,
  output logic [$clog2(LINE_CYCLES)-1:0]  cycleIdx,
  output logic                            lineStart
);

  clk_strobe_t strobe;

  cpu_line_clkgen_seq #(
    .HALF_TICKS   (HALF_TICKS),
    .STRETCH_TICKS(STRETCH_TICKS),
    .LINE_CYCLES  (LINE_CYCLES)
  ) i_seq (
    .clk     (clk),
    .rst     (rst),
    .cycleCnt(cycleIdx),
    .strobe  (strobe)
  );

  cpu_line_clkgen_phase i_phase (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .phi0     (phi0),
    .phi1     (phi1),
    .phi2     (phi2),
    .lineStart(lineStart)
  );

endmodule

// File: tb/test_cpu_line_clkgen.sv
module test_cpu_line_clkgen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phi0, phi1, phi2, lineStart;
  logic [6:0] cycleIdx;

  int total = 0;
  int bad   = 0;
  int mTick = 0;
  int mCyc  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cpu_line_clkgen i_cpu_line_clkgen (
    .clk(clk), .rst(rst), .phi0(phi0), .phi1(phi1), .phi2(phi2),
    .cycleIdx(cycleIdx), .lineStart(lineStart)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cycle=%0d tick=%0d actual=%0d expected=%0d",
               tag, what, mCyc, mTick, act, exp);
    end
  endtask

  // Compare every output against the tick-level model (R2, R3, R4, R5, R6, R7, R8)
  task automatic checkAll();
    int lowLen = (mCyc == 64) ? 9 : 7;
    int len    = lowLen + 7;
    bit eHi    = (mTick >= lowLen);
    bit eP1    = !eHi && mTick != 0 && mTick != lowLen - 1;
    bit eP2    = eHi && mTick != lowLen && mTick != len - 1;
    check((mCyc == 64) ? "R3" : "R2", "phi0", phi0, eHi);
    check("R6", "phi1", phi1, eP1);
    check("R7", "phi2", phi2, eP2);
    check("R4", "cycleIdx", cycleIdx, mCyc);
    check("R5", "lineStart", lineStart, (mTick == 0 && mCyc == 0));
    check("R8", "overlap", phi1 & phi2, 0);
  endtask

  task automatic advanceModel();
    int len = (mCyc == 64) ? 16 : 14;
    mTick++;
    if (mTick == len) begin
      mTick = 0;
      mCyc  = (mCyc == 64) ? 0 : mCyc + 1;
    end
  endtask

  task automatic step();
    @(posedge clk);
    advanceModel();
    @(negedge clk);
    checkAll();
  endtask

  // R1: state after reset
  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mTick = 0; mCyc = 0;
    check("R1", "phi0", phi0, 0);
    check("R1", "phi1", phi1, 0);
    check("R1", "phi2", phi2, 0);
    check("R1", "cycleIdx", cycleIdx, 0);
    check("R1", "lineStart", lineStart, 1);
  endtask

  // R2, R3, R4, R6, R7: two full lines checked tick by tick
  task automatic testTwoLines();
    for (int i = 0; i < 2 * 912; i++) step();
  endtask

  // R5, R3: line period and stretched-cycle split
  task automatic testLinePeriod();
    int gap = 0;
    int hiTicks = 0;
    int loTicks = 0;
    while (!lineStart) step();
    do begin
      step();
      gap++;
      if (cycleIdx == 64) begin
        if (phi0) hiTicks++; else loTicks++;
      end
    end while (!lineStart);
    check("R5", "line period", gap, 912);
    check("R5", "period mod 4", gap % 4, 0);
    check("R3", "long low ticks", loTicks, 9);
    check("R3", "long high ticks", hiTicks, 7);
  endtask

  // R9: reset in the middle of a line
  task automatic testMidReset();
    while (cycleIdx != 30) step();
    repeat (5) step();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mTick = 0; mCyc = 0;
    check("R9", "cycleIdx", cycleIdx, 0);
    check("R9", "lineStart", lineStart, 1);
    check("R9", "phi0", phi0, 0);
    for (int i = 0; i < 40; i++) step();
    check("R9", "cycleIdx after restart", cycleIdx, 2);
  endtask

  initial begin
    testReset();
    testTwoLines();
    testLinePeriod();
    testMidReset();
    testTwoLines();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule